// File: doc/BRIEF.md
# Gated Buffer-List DMA Engine

This engine copies packet data out of a local buffer RAM into buffers in a destination memory. Software keeps two address queues filled: one lists local buffers that already hold a packet, each with its length in words, and the other lists free destination buffers. Whenever both queues hold an entry, the engine pairs the two head entries and copies the source buffer word by word into the destination buffer. When the last word is written, it retires both entries together so software can post fresh buffers.

An external reservation controller owns the shared memory path. It pauses the engine through a hold input, and it learns through a pending output whether any source buffer is still waiting. A hold that arrives during a buffer stops the copy at the next word boundary. Once the hold is released, the copy continues from the saved word offset.

Completions are not reported one by one. A coalescer raises the interrupt when the number of retired buffers reaches a programmable threshold. It also raises the interrupt when completions have been waiting longer than a fixed timeout. Software clears the interrupt, and the clear also resets the completion count.

Top module: `dmae_engine`

## Requirements
- R1: A copy begins only when both queues are non-empty and hold is low; a source entry alone, or a destination entry alone, produces no memory read.
- R2: For a source entry of length L at address S paired with destination address D, word k (k = 0..L-1, in increasing order) is read from S+k and written to D+k. The read data returns one cycle after the read strobe, and exactly L writes occur.
- R3: While hold is high no read is issued, and at most one write (for a word already read) follows the rise of hold. After release the copy resumes at the saved offset, so the destination receives each word exactly once.
- R4: pending is high exactly while the source queue holds at least one entry, including the entry currently being copied.
- R5: After the last write of a buffer, retire pulses for one cycle and both head entries are removed together, in posting order.
- R6: A source entry of length 0 is retired without any memory read or write.
- R7: With threshold T non-zero, the interrupt rises on the clock edge at which the completion count since the last clear reaches T.
- R8: With completions counted and the interrupt low, the interrupt rises TIMEOUT_CYC cycles after the count first became non-zero. With no completions counted, it never rises.
- R9: A clear pulse drops the interrupt on the next edge and resets the completion count and the timeout timer.
- R10: During reset, pending, retire, interrupt, both memory strobes and both full flags are low.
- R11: Each queue holds DEPTH entries and raises its full flag when it holds DEPTH entries; a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_push_i | input | 1 | Post a filled local buffer |
| src_addr_i | input | AW | Local buffer start address |
| src_len_i | input | LW | Local buffer length in words |
| src_full_o | output | 1 | Source queue full |
| dst_push_i | input | 1 | Post a free destination buffer |
| dst_addr_i | input | AW | Destination buffer start address |
| dst_full_o | output | 1 | Destination queue full |
| hold_i | input | 1 | Reservation pause; no new reads while high |
| pending_o | output | 1 | A source buffer awaits transfer |
| rd_en_o | output | 1 | Local RAM read strobe |
| rd_addr_o | output | AW | Local RAM read address |
| rd_data_i | input | DW | Local RAM read data, one cycle after the strobe |
| wr_en_o | output | 1 | Destination write strobe |
| wr_addr_o | output | AW | Destination write address |
| wr_data_o | output | DW | Destination write data |
| retire_o | output | 1 | One-cycle pulse when a buffer pair is retired |
| irq_thresh_i | input | CW | Completion count that raises the interrupt; 0 disables the count trigger |
| irq_clear_i | input | 1 | Clear the interrupt, the count and the timer |
| irq_o | output | 1 | Coalesced completion interrupt |

## Verification
The assertions assume that the local RAM answers every read strobe with data in the following cycle. They also assume that hold is a synchronous level that can change in any cycle, and that the clear input is a single-cycle pulse. The bench models the RAM as a registered array that updates only on a read strobe. It drives hold, the pushes and the clear only at falling edges, each for whole cycles. Every source entry posted by the bench has a length below the local RAM span, so no copy wraps past the end of the address space.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_RETIRE = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/dmae_fifo.sv
module dmae_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]   rp;
        logic [PW-1:0]   wp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (s_q.cnt != CNTW'(DEPTH));
    assign do_pop  = pop && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = bump(s_q.wp);
        if (do_pop)  s_d.rp = bump(s_q.rp);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= din;
    end

    assign dout  = mem_q[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNTW'(DEPTH));

    // R11: a push into a full queue with no pop leaves the occupancy unchanged
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> $stable(s_q.cnt));
    // R11: occupancy never exceeds the depth
    a_r11_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNTW'(DEPTH));
endmodule

// File: rtl/dmae_coalesce.sv
module dmae_coalesce #(
    parameter int CW          = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          clear_i,
    output logic          irq_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] tmr;
        logic          irq;
    } co_st_t;

    co_st_t s_q, s_d;
    logic [CW-1:0] base;
    logic counting, to_hit, th_hit;

    always_comb begin
        s_d      = s_q;
        base     = clear_i ? '0 : s_q.cnt;
        s_d.cnt  = (done_i && (base != '1)) ? base + 1'b1 : base;
        counting = (s_q.cnt != '0) && !s_q.irq && !clear_i;
        s_d.tmr  = counting ? s_q.tmr + 1'b1 : '0;
        to_hit   = counting && (s_q.tmr == TW'(TIMEOUT_CYC - 1));
        th_hit   = (thresh_i != '0) && (s_d.cnt >= thresh_i);
        s_d.irq  = (s_q.irq && !clear_i) || th_hit || to_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;

    // R9: a clear without a simultaneous completion leaves the interrupt low
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !done_i |=> !irq_o);
    // R7: reaching the threshold raises the interrupt on the next edge
    a_r7_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !clear_i && (thresh_i != '0) &&
        ({1'b0, s_q.cnt} + 1'b1 >= {1'b0, thresh_i}) |=> irq_o);
    // R8: the interrupt never rises without a completion behind it
    a_r8_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(done_i) || ($past(s_q.cnt) != '0));
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
    import dmae_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int LW          = 6,
    parameter int DEPTH       = 4,
    parameter int CW          = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_push_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [LW-1:0] src_len_i,
    output logic          src_full_o,
    input  logic          dst_push_i,
    input  logic [AW-1:0] dst_addr_i,
    output logic          dst_full_o,
    input  logic          hold_i,
    output logic          pending_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          retire_o,
    input  logic [CW-1:0] irq_thresh_i,
    input  logic          irq_clear_i,
    output logic          irq_o
);
    localparam int SRC_W = AW + LW;

    typedef struct packed {
        xfer_state_e   st;
        logic [LW-1:0] off;
    } eng_st_t;

    eng_st_t s_q, s_d;
    logic [SRC_W-1:0] src_head;
    logic [AW-1:0]    src_base, dst_base;
    logic [LW-1:0]    src_len;
    logic             src_empty, dst_empty, pop_pair;

    dmae_fifo #(.W(SRC_W), .DEPTH(DEPTH)) u_src_q (
        .clk(clk), .rst_n(rst_n), .push(src_push_i), .din({src_addr_i, src_len_i}),
        .pop(pop_pair), .dout(src_head), .empty(src_empty), .full(src_full_o));

    dmae_fifo #(.W(AW), .DEPTH(DEPTH)) u_dst_q (
        .clk(clk), .rst_n(rst_n), .push(dst_push_i), .din(dst_addr_i),
        .pop(pop_pair), .dout(dst_base), .empty(dst_empty), .full(dst_full_o));

    assign src_base = src_head[SRC_W-1:LW];
    assign src_len  = src_head[LW-1:0];

    always_comb begin
        s_d      = s_q;
        rd_en_o  = 1'b0;
        wr_en_o  = 1'b0;
        pop_pair = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (!src_empty && !dst_empty && !hold_i) begin
                    s_d.off = '0;
                    s_d.st  = (src_len == '0) ? ST_RETIRE : ST_READ;
                end
            end
            ST_READ: begin
                if (!hold_i) begin
                    rd_en_o = 1'b1;
                    s_d.st  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                wr_en_o = 1'b1;
                if (s_q.off == src_len - 1'b1) begin
                    s_d.st = ST_RETIRE;
                end else begin
                    s_d.off = s_q.off + 1'b1;
                    s_d.st  = ST_READ;
                end
            end
            default: begin
                pop_pair = 1'b1;
                s_d.off  = '0;
                s_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, off: '0};
        else        s_q <= s_d;
    end

    assign rd_addr_o = src_base + AW'(s_q.off);
    assign wr_addr_o = dst_base + AW'(s_q.off);
    assign wr_data_o = rd_data_i;
    assign retire_o  = pop_pair;
    assign pending_o = !src_empty;

    dmae_coalesce #(.CW(CW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_coalesce (
        .clk(clk), .rst_n(rst_n), .done_i(pop_pair), .thresh_i(irq_thresh_i),
        .clear_i(irq_clear_i), .irq_o(irq_o));

    // R2: every read is followed by a write of its data in the next cycle
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> wr_en_o);
    // R2: no write without a read in the cycle before
    a_r2_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rd_en_o));
    // R3: a hold lasting two cycles silences both memory strobes
    a_r3_quiet_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i && $past(hold_i) |-> !rd_en_o && !wr_en_o);
    // R1: reads only happen with a source and a destination entry present
    a_r1_paired_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !src_empty && !dst_empty);
    // R5: a retire always removes a pair that exists
    a_r5_retire_pair: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> !src_empty && !dst_empty);
endmodule

// File: tb/dmae_engine_bench.sv
`timescale 1ns/1ps
module dmae_engine_bench;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = 6;
    localparam int CW = 4;
    localparam int TMO = 40;

    // vector fields: {source address, length, destination address}
    localparam logic [21:0] VECS [4] = '{
        {8'h10, 6'd1,  8'h80},
        {8'h20, 6'd5,  8'h90},
        {8'h40, 6'd12, 8'hA0},
        {8'hF0, 6'd3,  8'h20}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic src_push, dst_push, hold, irq_clear;
    logic [AW-1:0] src_addr, dst_addr;
    logic [LW-1:0] src_len;
    logic [CW-1:0] thresh;
    logic src_full, dst_full, pending, rd_en, wr_en, retire, irq;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    logic [DW-1:0] lmem [256];
    logic [DW-1:0] hmem [256];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dmae_engine #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(4), .CW(CW), .TIMEOUT_CYC(TMO)) u_dmae_engine (
        .clk(clk), .rst_n(rst_n),
        .src_push_i(src_push), .src_addr_i(src_addr), .src_len_i(src_len), .src_full_o(src_full),
        .dst_push_i(dst_push), .dst_addr_i(dst_addr), .dst_full_o(dst_full),
        .hold_i(hold), .pending_o(pending),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .retire_o(retire), .irq_thresh_i(thresh), .irq_clear_i(irq_clear), .irq_o(irq));

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= lmem[rd_addr];
            rd_cnt  <= rd_cnt + 1;
        end
        if (wr_en) begin
            hmem[wr_addr] <= wr_data;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mismatches(input int s, input int d, input int l);
        int bad = 0;
        for (int k = 0; k < l; k++)
            if (hmem[(d + k) & 255] !== lmem[(s + k) & 255]) bad++;
        return bad;
    endfunction

    task automatic push_src(input logic [AW-1:0] a, input logic [LW-1:0] l);
        src_addr = a; src_len = l; src_push = 1'b1;
        @(negedge clk);
        src_push = 1'b0;
    endtask

    task automatic push_dst(input logic [AW-1:0] a);
        dst_addr = a; dst_push = 1'b1;
        @(negedge clk);
        dst_push = 1'b0;
    endtask

    task automatic pulse_clear();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic wait_retire(input string req);
        int k = 0;
        while (!retire && k < 400) begin
            @(negedge clk);
            k++;
        end
        if (k >= 400) chk(req, "retire seen", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int w0, r0, w1, k, nret;
        for (int i = 0; i < 256; i++) begin
            lmem[i] = DW'(i * 37 + 5) ^ 16'hA500;
            hmem[i] = '0;
        end
        rst_n = 1'b0; src_push = 0; dst_push = 0; hold = 0; irq_clear = 0;
        src_addr = '0; dst_addr = '0; src_len = '0; thresh = 4'd15;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk("R10", "pending", int'(pending), 0);
        chk("R10", "retire", int'(retire), 0);
        chk("R10", "irq", int'(irq), 0);
        chk("R10", "strobes", int'(rd_en | wr_en), 0);
        chk("R10", "full flags", int'(src_full | dst_full), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R5: table of transfers
        for (int i = 0; i < 4; i++) begin
            w0 = wr_cnt;
            push_src(VECS[i][21:14], VECS[i][13:8]);
            push_dst(VECS[i][7:0]);
            wait_retire("R5");
            @(negedge clk);
            chk("R2", "word mismatches", mismatches(VECS[i][21:14], VECS[i][7:0], VECS[i][13:8]), 0);
            chk("R2", "write count", wr_cnt - w0, int'(VECS[i][13:8]));
        end

        // R1/R4: source alone does not start
        w0 = wr_cnt; r0 = rd_cnt;
        push_src(8'h30, 6'd4);
        repeat (5) @(negedge clk);
        chk("R1", "reads without destination", rd_cnt - r0, 0);
        chk("R4", "pending with source queued", int'(pending), 1);
        // R3: hold blocks the start
        hold = 1'b1;
        push_dst(8'hC0);
        repeat (5) @(negedge clk);
        chk("R3", "reads under hold", rd_cnt - r0, 0);
        // R3: hold in mid buffer
        hold = 1'b0;
        k = 0;
        while (wr_cnt - w0 < 2 && k < 50) begin
            @(negedge clk);
            k++;
        end
        hold = 1'b1;
        w1 = wr_cnt - w0;
        repeat (6) @(negedge clk);
        chk("R3", "writes stop under hold", int'(wr_cnt - w0 <= w1 + 1), 1);
        chk("R4", "pending during in-flight copy", int'(pending), 1);
        hold = 1'b0;
        wait_retire("R3");
        @(negedge clk);
        chk("R3", "resumed data", mismatches(8'h30, 8'hC0, 4), 0);
        chk("R3", "total writes", wr_cnt - w0, 4);
        chk("R4", "pending after retire", int'(pending), 0);

        // R6: zero length
        w0 = wr_cnt; r0 = rd_cnt;
        push_src(8'h50, 6'd0);
        push_dst(8'h60);
        wait_retire("R6");
        @(negedge clk);
        chk("R6", "writes", wr_cnt - w0, 0);
        chk("R6", "reads", rd_cnt - r0, 0);

        // R11: queue depth and dropped pushes
        hold = 1'b1;
        for (int i = 0; i < 5; i++) push_src(AW'(8'h70 + i), 6'd1);
        for (int i = 0; i < 5; i++) push_dst(AW'(8'hB0 + i));
        chk("R11", "source full", int'(src_full), 1);
        chk("R11", "destination full", int'(dst_full), 1);
        hold = 1'b0;
        nret = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (retire) nret++;
        end
        chk("R11", "retired pairs", nret, 4);
        chk("R11", "fourth buffer copied", int'(hmem[8'hB3] === lmem[8'h73]), 1);
        chk("R11", "dropped destination untouched", int'(hmem[8'hB4]), 0);

        // R7: threshold of two
        pulse_clear();
        thresh = 4'd2;
        push_src(8'h08, 6'd2);
        push_dst(8'hD0);
        wait_retire("R7");
        @(negedge clk);
        chk("R7", "irq after one", int'(irq), 0);
        push_src(8'h0C, 6'd2);
        push_dst(8'hD4);
        wait_retire("R7");
        @(negedge clk);
        chk("R7", "irq after two", int'(irq), 1);

        // R9: clear drops irq and resets the count
        pulse_clear();
        chk("R9", "irq after clear", int'(irq), 0);
        push_src(8'h18, 6'd1);
        push_dst(8'hD8);
        wait_retire("R9");
        @(negedge clk);
        chk("R9", "count restarted", int'(irq), 0);

        // R8: timeout with one completion pending
        repeat (38) @(negedge clk);
        chk("R8", "irq before timeout", int'(irq), 0);
        repeat (2) @(negedge clk);
        chk("R8", "irq at timeout", int'(irq), 1);
        pulse_clear();
        repeat (60) @(negedge clk);
        chk("R8", "no irq without completions", int'(irq), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule